// File: doc/BRIEF.md
# Linked-List Command Packet Walker

The walker follows a chain of command packets held in system memory and hands every payload word to a downstream command consumer. Each packet begins with a header word whose top byte is the number of payload words that follow it. Its low 24 bits are the byte address of the next packet. The walker fetches headers and payload one word at a time through a single-outstanding memory read port. It presents payload words on a valid/ready stream and keeps a running estimate of the processing cost. It stops when the address it is about to visit carries the end-of-list flag. It also stops if it has already visited a configurable number of packets, so a chain that loops back on itself cannot hold it forever.

A walk begins with a one-cycle `start` pulse that carries the first packet address. While the walk runs, `busy` is high. When it ends, `done` pulses for one cycle. In that same cycle `total_cost`, `node_count`, `last_addr` and `limit_hit` describe the finished walk, and they hold those values until the next start.

The controller is a single state machine with eight states:
- `ST_IDLE`: waits for `start`.
- `ST_TEST`: decides between ending and fetching the next header.
- `ST_HREQ`: issues the header read.
- `ST_HWAIT`: waits for header data.
- `ST_PREQ`: issues a payload read.
- `ST_PWAIT`: waits for payload data.
- `ST_POUT`: offers the payload word to the sink.
- `ST_FINISH`: raises `done`.

Its transitions are:
- IDLE→TEST on start.
- TEST→FINISH on the end flag or on the node limit.
- TEST→HREQ otherwise.
- HREQ→HWAIT.
- HWAIT→TEST when the header has zero length.
- HWAIT→PREQ when the header has a nonzero length.
- PREQ→PWAIT.
- PWAIT→POUT when data returns.
- POUT→PREQ when the sink takes the word and more words remain.
- POUT→TEST when the sink takes the last word.
- FINISH→IDLE.

Top module: `lw_walker`

## Requirements
- R1: After reset `busy`, `done`, `out_valid` and `mem_req` are 0, and no memory read or output word is issued while the walker is idle.
- R2: The start address is reduced to its low 24 bits (bits 31:24 are ignored). A start address with bit 23 set ends the walk with zero nodes, zero cost and `last_addr` equal to that address.
- R3: A header word is decoded as length = bits 31:24 and next address = bits 23:0. `node_count` equals the number of headers read.
- R4: Every memory read uses word index = address bits 20:2, so address bits 22:21 have no effect on which word is read. At most one read is outstanding: `mem_req` is a single-cycle pulse and is followed by a wait for `mem_rvalid`.
- R5: Payload words are read from the word indices immediately following the header, in ascending order. They are emitted in that order, each exactly once.
- R6: A node with length 0 emits no word and the walker still follows its next address.
- R7: `total_cost` is the sum over visited nodes of 10, plus 5 plus the length when the length is nonzero.
- R8: The walk ends when bit 23 of the address about to be visited is set, and `last_addr` reports that address.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is unchanged.
- R10: When `node_count` has reached NODE_LIMIT and the next address is not flagged, the walk ends with `limit_hit` = 1. In that case `last_addr` is the address that was not visited.
- R11: `done` is a one-cycle pulse, and `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (sampled only when idle) |
| start_addr | input | 32 | Byte address of the first packet |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 19 | Word index of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Payload word offered |
| out_data | output | 32 | Payload word |
| out_ready | input | 1 | Sink accepts the word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished (one cycle) |
| limit_hit | output | 1 | Walk stopped by the node limit |
| total_cost | output | COST_W | Accumulated cost of the walk |
| node_count | output | CNT_W | Headers read in the walk |
| last_addr | output | 24 | Address at which the walk stopped |

## Verification
The bench sweeps chain lengths from one to eight nodes across three memory latency patterns and three sink stall patterns, and compares every forwarded word and the cost against totals it computes itself. Some chains contain only zero-length nodes; a walker that fetched payload for them would forward stray words or overcharge them. Other chains contain a 255-word node, which exposes a walker that truncates the length field. The next-address fields carry junk in bits 22:21, so a walker that indexed memory with too many address bits would fetch the wrong words. A self-linked node must stop exactly at the limit, and a start pulse issued mid-walk must not restart or redirect it; a walker that ignored the limit would never finish, and one that honoured the stray start would change the stream.

// File: rtl/lw_pkg.sv
package lw_pkg;
    localparam int ADDR_W = 24;
    localparam int LEN_W  = 8;
    localparam int MIDX_W = 19;
    localparam int WORD_W = 32;
    localparam int END_BIT = 23;

    typedef enum logic [2:0] {
        ST_IDLE, ST_TEST, ST_HREQ, ST_HWAIT,
        ST_PREQ, ST_PWAIT, ST_POUT, ST_FINISH
    } walk_state_t;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] next;
    } node_hdr_t;

    function automatic logic [MIDX_W-1:0] word_index(input logic [ADDR_W-1:0] a);
        return a[MIDX_W+1:2];
    endfunction
endpackage

// File: rtl/lw_cost_acc.sv
module lw_cost_acc #(
    parameter int COST_W     = 32,
    parameter int CNT_W      = 14,
    parameter int LEN_W      = 8,
    parameter int NODE_FIXED = 10,
    parameter int LEN_BASE   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_en,
    input  logic [LEN_W-1:0]  len,
    output logic [COST_W-1:0] cost,
    output logic [CNT_W-1:0]  nodes
);
    logic [COST_W-1:0] charge;

    always_comb begin
        charge = COST_W'(NODE_FIXED);
        if (len != '0)
            charge = charge + COST_W'(LEN_BASE) + COST_W'(len);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cost  <= '0;
            nodes <= '0;
        end else if (clr) begin
            cost  <= '0;
            nodes <= '0;
        end else if (add_en) begin
            cost  <= cost + charge;
            nodes <= nodes + 1'b1;
        end
    end
endmodule

// File: rtl/lw_payload_ctr.sv
module lw_payload_ctr #(
    parameter int MIDX_W = 19,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MIDX_W-1:0] hdr_idx,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              step,
    output logic [MIDX_W-1:0] idx,
    output logic              last
);
    logic [LEN_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            remaining <= '0;
        end else if (load) begin
            idx       <= hdr_idx + 1'b1;
            remaining <= load_len;
        end else if (step) begin
            idx       <= idx + 1'b1;
            remaining <= remaining - 1'b1;
        end
    end

    assign last = (remaining == LEN_W'(1));
endmodule

// File: rtl/lw_walker.sv
module lw_walker
    import lw_pkg::*;
#(
    parameter int NODE_LIMIT = 8192,
    parameter int COST_W     = 32,
    parameter int NODE_FIXED = 10,
    parameter int LEN_BASE   = 5,
    localparam int CNT_W     = $clog2(NODE_LIMIT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [31:0]         start_addr,
    output logic                mem_req,
    output logic [MIDX_W-1:0]   mem_addr,
    input  logic                mem_rvalid,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_data,
    input  logic                out_ready,
    output logic                busy,
    output logic                done,
    output logic                limit_hit,
    output logic [COST_W-1:0]   total_cost,
    output logic [CNT_W-1:0]    node_count,
    output logic [ADDR_W-1:0]   last_addr
);
    walk_state_t       state;
    logic [ADDR_W-1:0] cur_addr;
    logic [WORD_W-1:0] data_q;
    logic              limit_q;
    node_hdr_t         hdr;
    logic              hdr_take;
    logic              word_take;
    logic              walk_clr;
    logic [MIDX_W-1:0] pay_idx;
    logic              pay_last;

    assign hdr       = node_hdr_t'(mem_rdata);
    assign hdr_take  = (state == ST_HWAIT) && mem_rvalid;
    assign word_take = (state == ST_POUT) && out_ready;
    assign walk_clr  = (state == ST_IDLE) && start;

    lw_cost_acc #(
        .COST_W(COST_W), .CNT_W(CNT_W), .LEN_W(LEN_W),
        .NODE_FIXED(NODE_FIXED), .LEN_BASE(LEN_BASE)
    ) u_cost (
        .clk(clk), .rst_n(rst_n), .clr(walk_clr), .add_en(hdr_take),
        .len(hdr.len), .cost(total_cost), .nodes(node_count)
    );

    lw_payload_ctr #(.MIDX_W(MIDX_W), .LEN_W(LEN_W)) u_pay (
        .clk(clk), .rst_n(rst_n), .load(hdr_take),
        .hdr_idx(word_index(cur_addr)), .load_len(hdr.len),
        .step(word_take), .idx(pay_idx), .last(pay_last)
    );

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            data_q   <= '0;
            limit_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cur_addr <= start_addr[ADDR_W-1:0];
                        limit_q  <= 1'b0;
                        state    <= ST_TEST;
                    end
                end
                ST_TEST: begin
                    if (cur_addr[END_BIT]) begin
                        state <= ST_FINISH;
                    end else if (node_count == CNT_W'(NODE_LIMIT)) begin
                        limit_q <= 1'b1;
                        state   <= ST_FINISH;
                    end else begin
                        state <= ST_HREQ;
                    end
                end
                ST_HREQ:  state <= ST_HWAIT;
                ST_HWAIT: begin
                    if (mem_rvalid) begin
                        cur_addr <= hdr.next;
                        state    <= (hdr.len == '0) ? ST_TEST : ST_PREQ;
                    end
                end
                ST_PREQ:  state <= ST_PWAIT;
                ST_PWAIT: begin
                    if (mem_rvalid) begin
                        data_q <= mem_rdata;
                        state  <= ST_POUT;
                    end
                end
                ST_POUT: begin
                    if (out_ready)
                        state <= pay_last ? ST_TEST : ST_PREQ;
                end
                ST_FINISH: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_addr  = pay_idx;
        out_valid = 1'b0;
        done      = 1'b0;
        busy      = 1'b1;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_HREQ: begin
                mem_req  = 1'b1;
                mem_addr = word_index(cur_addr);
            end
            ST_PREQ:   mem_req = 1'b1;
            ST_POUT:   out_valid = 1'b1;
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    assign out_data  = data_q;
    assign last_addr = cur_addr;
    assign limit_hit = limit_q;
endmodule

// File: rtl/lw_walker_chk.sv
module lw_walker_chk #(
    parameter int NODE_LIMIT = 8192,
    parameter int COST_W     = 32,
    parameter int CNT_W      = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              out_valid,
    input logic [31:0]       out_data,
    input logic              out_ready,
    input logic              busy,
    input logic              done,
    input logic              limit_hit,
    input logic [CNT_W-1:0]  node_count,
    input logic [23:0]       last_addr
);
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !out_valid));

    p_single_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    p_end_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (last_addr[23] || limit_hit));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_limit_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        node_count <= CNT_W'(NODE_LIMIT));

    p_limit_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && limit_hit) |-> (node_count == CNT_W'(NODE_LIMIT)));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind lw_walker lw_walker_chk #(
    .NODE_LIMIT(NODE_LIMIT), .COST_W(COST_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .busy(busy), .done(done),
    .limit_hit(limit_hit), .node_count(node_count), .last_addr(last_addr)
);

// File: tb/lw_walker_bench.sv
module lw_walker_bench;
    localparam int LIM = 16;
    localparam int CW  = $clog2(LIM + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic        mem_req;
    logic [18:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ready = 1'b1;
    logic        busy, done, limit_hit;
    logic [31:0] total_cost;
    logic [CW-1:0] node_count;
    logic [23:0] last_addr;

    always #2.5 clk = ~clk;

    lw_walker #(.NODE_LIMIT(LIM)) u_lw_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .busy(busy), .done(done), .limit_hit(limit_hit),
        .total_cost(total_cost), .node_count(node_count), .last_addr(last_addr)
    );

    int checks = 0;
    int errors = 0;
    logic [31:0] mem [int unsigned];
    logic [31:0] got[$];
    logic [31:0] exp_q[$];
    int unsigned exp_cost, exp_nodes;
    logic [23:0] exp_last;
    logic        exp_limit;
    logic [31:0] rnd = 32'h1234_5679;
    int          lat_mode = 0;
    int          ready_mode = 0;
    logic [15:0] rdy_lfsr = 16'hACE1;
    int          stall_err = 0;
    int          stall_seen = 0;
    logic        prev_stall = 1'b0;
    logic [31:0] prev_data = '0;
    logic        pend = 1'b0;
    logic [18:0] pend_idx = '0;
    int          wait_cnt = 0;
    int          cyc = 0;

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    function automatic int unsigned idx_of(input logic [23:0] a);
        return int'((a >> 2) & 24'h07FFFF);
    endfunction

    // memory model: single outstanding read, variable latency
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rvalid <= 1'b0;
        if (pend) begin
            if (wait_cnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem.exists(int'(pend_idx)) ? mem[int'(pend_idx)] : 32'hDEAD_BEEF;
                pend <= 1'b0;
            end else begin
                wait_cnt <= wait_cnt - 1;
            end
        end
        if (mem_req) begin
            pend     <= 1'b1;
            pend_idx <= mem_addr;
            wait_cnt <= (lat_mode == 0) ? 0 : (lat_mode == 1) ? 2 : (cyc % 4);
        end
    end

    // sink: capture words and watch stall stability
    always @(posedge clk) begin
        if (rst_n) begin
            if (prev_stall && !(out_valid && out_data == prev_data))
                stall_err <= stall_err + 1;
            if (out_valid && !out_ready) stall_seen <= stall_seen + 1;
            prev_stall <= out_valid && !out_ready;
            prev_data  <= out_data;
            if (out_valid && out_ready) got.push_back(out_data);
        end
    end

    always @(negedge clk) begin
        rdy_lfsr <= {rdy_lfsr[14:0], rdy_lfsr[15] ^ rdy_lfsr[13] ^ rdy_lfsr[12] ^ rdy_lfsr[10]};
        out_ready <= (ready_mode == 0) ? 1'b1 :
                     (ready_mode == 1) ? rdy_lfsr[0] : (rdy_lfsr[1:0] == 2'b11);
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // build a chain of n nodes; mode 0 random lengths, 1 all zero, 2 first node 255
    task automatic build_list(input int n, input int mode);
        logic [23:0] addr [8];
        mem.delete();
        exp_q.delete();
        exp_cost = 0;
        exp_nodes = n;
        exp_limit = 1'b0;
        for (int i = 0; i < n; i++) begin
            rnd = nxt(rnd);
            addr[i] = 24'h002000 + 24'(((i * 3 + 1) % 8) * 1024) + {1'b0, rnd[1:0], 21'h0};
        end
        for (int i = 0; i < n; i++) begin
            logic [7:0]  len;
            logic [23:0] nx;
            rnd = nxt(rnd);
            len = (mode == 1) ? 8'd0 : (mode == 2 && i == 0) ? 8'd255 : 8'(rnd[7:0] % 13);
            rnd = nxt(rnd);
            nx = (i == n - 1) ? {1'b1, rnd[22:0]} : addr[i + 1];
            if (i == n - 1) exp_last = nx;
            mem[idx_of(addr[i])] = {len, nx};
            for (int j = 0; j < int'(len); j++) begin
                rnd = nxt(rnd);
                mem[idx_of(addr[i]) + 1 + j] = rnd;
                exp_q.push_back(rnd);
            end
            exp_cost += 10 + ((len != 0) ? 5 + int'(len) : 0);
        end
        rnd = nxt(rnd);
        start_addr = {rnd[31:24], addr[0]};
    endtask

    task automatic run_walk(input logic [31:0] sa, input bit poke, input string tag);
        int n = 0;
        int mism = 0;
        got.delete();
        @(negedge clk);
        start = 1'b1;
        start_addr = sa;
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 40000) begin
            @(negedge clk);
            n++;
            if (poke && n == 6) begin
                start = 1'b1;
                start_addr = 32'h0000_1230;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(done == 1'b1, {tag, " R11 walk finished"}, done, 1);
        chk(got.size() == exp_q.size(), {tag, " R5 word count"}, got.size(), exp_q.size());
        for (int k = 0; k < got.size() && k < exp_q.size(); k++)
            if (got[k] !== exp_q[k]) mism++;
        chk(mism == 0, {tag, " R5 R4 word content/order"}, mism, 0);
        chk(total_cost == exp_cost, {tag, " R7 cost"}, total_cost, exp_cost);
        chk(node_count == CW'(exp_nodes), {tag, " R3 node count"}, node_count, exp_nodes);
        chk(last_addr == exp_last, {tag, " R8 last address"}, last_addr, exp_last);
        chk(limit_hit == exp_limit, {tag, " R10 limit flag"}, limit_hit, exp_limit);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, {tag, " R11 done pulse width"}, {done, busy}, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !out_valid && !mem_req, "R1 reset outputs",
            {busy, done, out_valid, mem_req}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !out_valid, "R1 idle stays quiet", {busy, mem_req, out_valid}, 0);

        // R2 flagged start address ends at once
        mem.delete();
        exp_q.delete();
        exp_cost = 0; exp_nodes = 0; exp_limit = 0; exp_last = 24'h8ABCDE;
        run_walk(32'h5A8A_BCDE, 1'b0, "R2 flagged start");

        // sweep chain length x latency x backpressure
        for (int n = 1; n <= 8; n++) begin
            for (int m = 0; m < 3; m++) begin
                lat_mode = m;
                ready_mode = (n + m) % 3;
                build_list(n, 0);
                run_walk(start_addr, 1'b0, "sweep");
            end
        end

        // R6 zero-length nodes only
        lat_mode = 1; ready_mode = 1;
        build_list(4, 1);
        chk(exp_cost == 40, "R6 expected cost of empty nodes", exp_cost, 40);
        run_walk(start_addr, 1'b0, "R6 zero-length chain");

        // R3 full length field
        lat_mode = 2; ready_mode = 2;
        build_list(2, 2);
        run_walk(start_addr, 1'b0, "R3 length 255");

        // R11 start ignored while busy
        lat_mode = 0; ready_mode = 1;
        build_list(5, 0);
        run_walk(start_addr, 1'b1, "R11 start while busy");

        // R10 self-linked node hits the limit
        mem.delete();
        exp_q.delete();
        mem[idx_of(24'h004000)] = {8'd2, 24'h004000};
        mem[idx_of(24'h004000) + 1] = 32'hCAFE_0001;
        mem[idx_of(24'h004000) + 2] = 32'hCAFE_0002;
        for (int k = 0; k < LIM; k++) begin
            exp_q.push_back(32'hCAFE_0001);
            exp_q.push_back(32'hCAFE_0002);
        end
        exp_cost = LIM * 17; exp_nodes = LIM; exp_limit = 1'b1; exp_last = 24'h004000;
        lat_mode = 0; ready_mode = 0;
        run_walk(32'h0000_4000, 1'b0, "R10 looping chain");

        // R9 backpressure observed and held
        chk(stall_seen > 0, "R9 stalls exercised", stall_seen, 1);
        chk(stall_err == 0, "R9 word held during stall", stall_err, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule